// File: doc/BRIEF.md
# Banked Global Register Set Switcher

This block holds the eight global registers that a processor core reads and writes. It also keeps four shadow copies of that set: normal, alternate, MMU and interrupt. Three bits of a 12-bit processor-state word choose which copy is live. When a state write changes those bits, the block moves the live registers into the bank being left. It then fills the live registers from the bank being entered, all within one clock edge. The core sees only the active set, through one combinational read port and one synchronous write port.

The selection is a sparse field of the state word, not a dense index. Alternate is bit 0, MMU is bit 10 and interrupt is bit 11. Any mix of these bits that is not a clean code falls back to the normal bank. An input flag handles parts that manage global levels another way: when it is set, the alternate bit is cleared from each incoming state before the bank is chosen.

Top module: `gbank_switch`

## Requirements
- R1: After reset the stored state word is 0x000 and every active register and every bank reads zero.
- R2: A state write stores `stateWrData & 0xF3F` (after R8), visible on `stateOut` the cycle after the write. With no state write, `stateOut` holds its value.
- R3: The selection field is `state & 0xC01`. Its codes map to banks as follows: 0x000 to normal, 0x001 to alternate, 0x400 to MMU and 0x800 to interrupt.
- R4: The selection codes 0x401, 0x801, 0xC00 and 0xC01 all select the normal bank.
- R5: When a state write changes the selection field, the bank being left receives the pre-edge active registers. On the same edge, the active registers take the contents of the bank being entered.
- R6: A state write that leaves the selection field unchanged copies nothing. The active registers and all banks keep their contents, even if other state bits change.
- R7: A selection change between two codes that both map to the same bank leaves the active registers unchanged. That bank then holds the active contents.
- R8: When `altDisable` is high during a state write, bit 0 of the new state is cleared before the state is stored and before the bank is selected.
- R9: A register write stores `wrData` into active register `wrAddr` on the clock edge. `rdData` always shows active register `rdAddr` without delay.
- R10: A register write in the same cycle as a bank swap is applied after the swap. It lands in the newly loaded set, and the bank being left saves the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| altDisable | input | 1 | Clears the alternate bit of each written state |
| stateWrEn | input | 1 | State word write strobe |
| stateWrData | input | 12 | New state word, before masking |
| stateOut | output | 12 | Stored state word |
| wrEn | input | 1 | Active register write strobe |
| wrAddr | input | 3 | Active register write index |
| wrData | input | 64 | Active register write data |
| rdAddr | input | 3 | Active register read index |
| rdData | output | 64 | Active register read data |

## Verification
Each bank is filled with its own pattern, then revisited in several orders. This separates a correct save and load from a swap that writes to or reads from the wrong bank. The fall-back codes are tried in two ways: as moves from and to the clean normal code, which must leave the active set untouched, and as moves to other banks. State writes that change only bits outside the selection show whether a copy fires when it should not. A register write in the same cycle as a swap, followed by a return to the left bank, shows which set the write reached. The flag is exercised with codes that hold bit 0, and a random run of mixed operations follows.

// File: rtl/gbank_pkg.sv
package gbank_pkg;
  localparam int STATE_W = 12;
  localparam logic [STATE_W-1:0] WR_MASK = 12'hF3F;
  localparam logic [STATE_W-1:0] SEL_MASK = 12'hC01;
  localparam int ALT_BIT = 0;
  localparam int MMU_BIT = 10;
  localparam int INTR_BIT = 11;
  localparam int NUM_BANKS = 4;

  typedef enum logic [1:0] {
    BANK_NORMAL = 2'd0,
    BANK_ALT    = 2'd1,
    BANK_MMU    = 2'd2,
    BANK_INTR   = 2'd3
  } bankSel_e;

  typedef struct packed {
    logic     swap;
    bankSel_e outBank;
    bankSel_e inBank;
  } swapCtl_t;

  function automatic bankSel_e decodeSel(input logic [STATE_W-1:0] sel);
    logic [STATE_W-1:0] altCode, mmuCode, intrCode;
    altCode  = '0; altCode[ALT_BIT]   = 1'b1;
    mmuCode  = '0; mmuCode[MMU_BIT]   = 1'b1;
    intrCode = '0; intrCode[INTR_BIT] = 1'b1;
    if (sel == altCode)       return BANK_ALT;
    else if (sel == mmuCode)  return BANK_MMU;
    else if (sel == intrCode) return BANK_INTR;
    else                      return BANK_NORMAL;
  endfunction
endpackage

// File: rtl/gbank_ctrl.sv
module gbank_ctrl
  import gbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               altDisable,
  input  logic               stateWrEn,
  input  logic [STATE_W-1:0] stateWrData,
  output logic [STATE_W-1:0] stateQ,
  output swapCtl_t           strobe
);
  logic [STATE_W-1:0] stateNext;
  logic [STATE_W-1:0] selOld;
  logic [STATE_W-1:0] selNew;

  always_comb begin
    stateNext = stateWrData & WR_MASK;
    if (altDisable) stateNext[ALT_BIT] = 1'b0;
  end

  assign selOld = stateQ & SEL_MASK;
  assign selNew = stateNext & SEL_MASK;

  always_comb begin
    strobe.swap    = stateWrEn && (selOld != selNew);
    strobe.outBank = decodeSel(selOld);
    strobe.inBank  = decodeSel(selNew);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= '0;
    else if (stateWrEn) stateQ <= stateNext;
  end

  // R2: state only moves on a write
  p_state_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stateWrEn |=> $stable(stateQ));

  // R8: folded alternate bit never lands in the stored state
  p_alt_fold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateWrEn && altDisable) |=> !stateQ[ALT_BIT]);

  // R6: equal selection never produces a swap strobe
  p_no_swap_same_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateWrEn && ((stateWrData & SEL_MASK & ~(STATE_W'(altDisable) << ALT_BIT))
                   == (stateQ & SEL_MASK))) |-> !strobe.swap);
endmodule

// File: rtl/gbank_datapath.sv
module gbank_datapath
  import gbank_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapCtl_t          strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  typedef logic [NUM_REGS-1:0][DATA_W-1:0] regSet_t;

  regSet_t                     activeQ;
  logic [NUM_BANKS-1:0][NUM_REGS-1:0][DATA_W-1:0] bankQ;
  regSet_t                     loadSet;
  logic                        sameBank;

  assign sameBank = (strobe.outBank == strobe.inBank);
  assign loadSet  = sameBank ? activeQ : bankQ[strobe.inBank];
  assign rdData   = activeQ[rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= '0;
      bankQ   <= '0;
    end else begin
      if (strobe.swap) begin
        bankQ[strobe.outBank] <= activeQ;
        activeQ               <= loadSet;
      end
      if (wrEn) activeQ[wrAddr] <= wrData;
    end
  end

  // R5: bank being left holds the pre-edge active set
  p_save_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swap |=> bankQ[$past(strobe.outBank)] == $past(activeQ));

  // R6: without a swap no bank changes
  p_banks_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.swap |=> $stable(bankQ));

  // R9: no swap and no write keeps the active set
  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.swap && !wrEn) |=> $stable(activeQ));

  // R7: swap between aliases of one bank keeps untouched active registers
  p_alias_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swap && sameBank && !wrEn) |=> $stable(activeQ));
endmodule

// File: rtl/gbank_switch.sv
module gbank_switch
  import gbank_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               altDisable,
  input  logic               stateWrEn,
  input  logic [STATE_W-1:0] stateWrData,
  output logic [STATE_W-1:0] stateOut,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData
);
  swapCtl_t swapCtl;

  gbank_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .altDisable  (altDisable),
    .stateWrEn   (stateWrEn),
    .stateWrData (stateWrData),
    .stateQ      (stateOut),
    .strobe      (swapCtl)
  );

  gbank_datapath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (swapCtl),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: tb/gbank_switch_tb.sv
`timescale 1ns/100ps
module gbank_switch_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        altDisable = 1'b0;
  logic        stateWrEn = 1'b0;
  logic [11:0] stateWrData = '0;
  logic [11:0] stateOut;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [63:0] rdData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [63:0] mAct [8];
  logic [63:0] mBank [4][8];
  logic [11:0] mState;

  gbank_switch u_dut (
    .clk(clk), .rstN(rstN), .altDisable(altDisable),
    .stateWrEn(stateWrEn), .stateWrData(stateWrData), .stateOut(stateOut),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int bankOf(input logic [11:0] sel);
    case (sel)
      12'h001: return 1;
      12'h400: return 2;
      12'h800: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    mState = '0;
    for (int r = 0; r < 8; r++) begin
      mAct[r] = '0;
      for (int b = 0; b < 4; b++) mBank[b][r] = '0;
    end
  endtask

  task automatic modelStep(input bit sWe, input logic [11:0] sData, input bit alt,
                           input bit rWe, input logic [2:0] rA, input logic [63:0] rD);
    logic [11:0] ns;
    int ob, ib;
    ns = sData & 12'hF3F;
    if (alt) ns[0] = 1'b0;
    if (sWe) begin
      if ((mState & 12'hC01) != (ns & 12'hC01)) begin
        ob = bankOf(mState & 12'hC01);
        ib = bankOf(ns & 12'hC01);
        for (int r = 0; r < 8; r++) mBank[ob][r] = mAct[r];
        for (int r = 0; r < 8; r++) mAct[r] = mBank[ib][r];
      end
      mState = ns;
    end
    if (rWe) mAct[rA] = rD;
  endtask

  task automatic compareAll(input string tag);
    checks++;
    if (stateOut !== mState) begin
      fails++;
      $display("FAIL %s stateOut: actual %h expected %h", tag, stateOut, mState);
    end
    for (int a = 0; a < 8; a++) begin
      rdAddr = 3'(a);
      #0.1;
      checks++;
      if (rdData !== mAct[a]) begin
        fails++;
        $display("FAIL %s reg %0d: actual %h expected %h", tag, a, rdData, mAct[a]);
      end
    end
  endtask

  task automatic step(input string tag, input bit sWe, input logic [11:0] sData,
                      input bit alt, input bit rWe, input logic [2:0] rA,
                      input logic [63:0] rD);
    stateWrEn = sWe; stateWrData = sData; altDisable = alt;
    wrEn = rWe; wrAddr = rA; wrData = rD;
    @(posedge clk);
    modelStep(sWe, sData, alt, rWe, rA, rD);
    @(negedge clk);
    stateWrEn = 1'b0; wrEn = 1'b0; altDisable = 1'b0;
    compareAll(tag);
  endtask

  task automatic fill(input string tag, input logic [63:0] base);
    for (int r = 0; r < 8; r++)
      step(tag, 1'b0, 12'h000, 1'b0, 1'b1, 3'(r), base + 64'(r));
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");
    fill("R9", 64'hA000_0000_0000_0000);
    step("R3", 1'b1, 12'h001, 1'b0, 1'b0, 3'd0, 64'd0);
    fill("R9", 64'hB000_0000_0000_0000);
    step("R3", 1'b1, 12'h400, 1'b0, 1'b0, 3'd0, 64'd0);
    fill("R9", 64'hC000_0000_0000_0000);
    step("R3", 1'b1, 12'h800, 1'b0, 1'b0, 3'd0, 64'd0);
    fill("R9", 64'hD000_0000_0000_0000);
    step("R5", 1'b1, 12'h000, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R2", 1'b1, 12'hFFF, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R7", 1'b1, 12'h13E, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R6", 1'b1, 12'h030, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R4", 1'b1, 12'h401, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R4", 1'b1, 12'hC00, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R4", 1'b1, 12'h801, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R5", 1'b1, 12'h001, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R6", 1'b1, 12'h0F1, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R8", 1'b1, 12'h401, 1'b1, 1'b0, 3'd0, 64'd0);
    step("R8", 1'b1, 12'h001, 1'b1, 1'b0, 3'd0, 64'd0);
    step("R10", 1'b1, 12'h800, 1'b0, 1'b1, 3'd3, 64'h1234_5678_9ABC_DEF0);
    step("R10", 1'b1, 12'h000, 1'b0, 1'b0, 3'd0, 64'd0);
    step("R10", 1'b1, 12'h800, 1'b0, 1'b0, 3'd0, 64'd0);
    for (int i = 0; i < 200; i++) begin
      logic [11:0] s;
      case ($urandom_range(0, 5))
        0: s = 12'h000; 1: s = 12'h001; 2: s = 12'h400;
        3: s = 12'h800; 4: s = 12'hC01; default: s = 12'($urandom);
      endcase
      step("R5", 1'($urandom), s, 1'($urandom), 1'($urandom),
           3'($urandom), {$urandom, $urandom});
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule